// File: doc/BRIEF.md
# CAN Dual Receive Buffer Manager

This block sits between a CAN protocol engine and a host processor and manages two frame-sized receive slots. At any moment the host owns one slot and reads its frame. The other slot is kept free for the engine. A store strobe from the engine writes a complete received frame into a free slot. A release command from the host hands its slot back. When the second slot already holds a frame, that frame passes to the host in the same step. A single status flag tells the host whether its slot holds an unread frame.

The engine also parks every outgoing frame in a free receive slot when transmission starts. If arbitration is lost, the frame that arrives next lands in that reserved slot. If the transmission finishes, the reservation is dropped without disturbing the host. Because transmissions take slots, they can cause overrun just as receptions can. An overrun flag records every frame that had to be dropped for lack of space. The flag stays set until the host clears it explicitly.

Top module: `can_rx_dualbuf`

## Requirements
- R1: After reset both slots are empty, and `rx_full` and `overrun` read 0.
- R2: A `rx_store` pulse with no slot reserved and the host slot empty makes `rx_full` read 1 on the following cycle, with the stored frame on `host_frame`.
- R3: `host_release` while `rx_full` is 1 and the other slot is empty makes `rx_full` read 0 on the next cycle. `host_release` while `rx_full` is 0 has no effect.
- R4: `host_release` while both slots hold frames keeps `rx_full` at 1 and presents the older waiting frame on `host_frame` on the next cycle. Frames always reach the host in arrival order.
- R5: A `rx_store` with both slots occupied drops the new frame and leaves the host frame unchanged. It sets `overrun` on the next cycle.
- R6: `overrun` clears only on `host_clr_ovr`. A new overrun event in the same cycle as `host_clr_ovr` leaves it set.
- R7: `tx_start` reserves a free slot for the outgoing frame without changing `rx_full`. If no slot is free, it sets `overrun` instead.
- R8: `tx_done` frees the reserved slot without raising `rx_full`. The slot can then take a new frame.
- R9: A `rx_store` while a slot is reserved writes the frame into the reserved slot, which becomes a normal full slot queued behind any older frame.
- R10: When `host_release` and `rx_store` arrive in the same cycle, the release is handled first. The freed slot can take the incoming frame, with no overrun.
- R11: `tx_start` while a slot is already reserved is ignored. No second slot is taken and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_store | input | 1 | Engine strobe: a complete received frame is on `rx_frame` |
| rx_frame | input | FRAME_W | Received frame contents |
| tx_start | input | 1 | Engine strobe: transmission begins, park `tx_frame` in a free slot |
| tx_frame | input | FRAME_W | Outgoing frame contents |
| tx_done | input | 1 | Transmission completed successfully, drop the parked copy |
| host_release | input | 1 | Host hands back the slot it owns |
| host_clr_ovr | input | 1 | Host clears the overrun flag |
| rx_full | output | 1 | Host slot holds an unread frame |
| overrun | output | 1 | A frame was dropped because no slot was free |
| host_frame | output | FRAME_W | Contents of the slot the host owns |

## Verification
The bench builds the block with `FRAME_W` = 16 and a two-stage reset synchronizer. The narrow frame lets every stored frame carry a distinct sequence tag, so a lost, duplicated or reordered frame shows up directly on `host_frame`. The two-stage release keeps the start-up window short. With only two slots, a few strobes are enough to reach the full, reserved and overrun corners. The bench drives the same-cycle collisions of release, store, transmit start, transmit completion and overrun clear, both in directed runs and in several thousand random cycles.

// File: rtl/can_rxb_pkg.sv
package can_rxb_pkg;

  localparam int NUM_SLOTS = 2;
  localparam int IDX_W     = $clog2(NUM_SLOTS);

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_HELD  = 2'd1,
    SLOT_FULL  = 2'd2
  } slot_state_e;

endpackage

// File: rtl/rxb_rst_sync.sv
module rxb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rxb_owner_fsm.sv
module rxb_owner_fsm
  import can_rxb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 rx_store,
  input  logic                 tx_start,
  input  logic                 tx_done,
  input  logic                 host_release,
  output logic [NUM_SLOTS-1:0] wr_en,
  output logic [NUM_SLOTS-1:0] wr_tx,
  output logic [IDX_W-1:0]     host_sel,
  output logic [NUM_SLOTS-1:0] slot_full,
  output logic                 rx_full,
  output logic                 ovr_evt
);

  slot_state_e st_q [NUM_SLOTS];
  slot_state_e st_n [NUM_SLOTS];
  logic [IDX_W-1:0] host_q, host_n;

  logic             held_a, free_a, held_b, free_b;
  logic [IDX_W-1:0] held_a_idx, free_a_idx, free_b_idx;

  // Next-state: release, then transmit completion, then store, then transmit start
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) st_n[i] = st_q[i];
    host_n  = host_q;
    wr_en   = '0;
    wr_tx   = '0;
    ovr_evt = 1'b0;

    // host hands back its slot; the older waiting frame moves over at once
    if (host_release && (st_q[host_q] == SLOT_FULL)) begin
      st_n[host_q] = SLOT_EMPTY;
      if (st_q[host_q ^ 1'b1] == SLOT_FULL) host_n = host_q ^ 1'b1;
    end

    // successful transmission: parked copy is discarded
    if (tx_done) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (st_n[i] == SLOT_HELD) st_n[i] = SLOT_EMPTY;
      end
    end

    // scan for the store stage
    held_a = 1'b0; held_a_idx = '0;
    free_a = 1'b0; free_a_idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (st_n[i] == SLOT_HELD) begin
        held_a     = 1'b1;
        held_a_idx = IDX_W'(i);
      end
      if ((st_n[i] == SLOT_EMPTY) && (!free_a || (IDX_W'(i) != host_n))) begin
        free_a     = 1'b1;
        free_a_idx = IDX_W'(i);
      end
    end

    if (rx_store) begin
      if (held_a) begin
        st_n[held_a_idx]  = SLOT_FULL;
        wr_en[held_a_idx] = 1'b1;
      end else if (free_a) begin
        st_n[free_a_idx]  = SLOT_FULL;
        wr_en[free_a_idx] = 1'b1;
      end else begin
        ovr_evt = 1'b1;
      end
    end

    // host slot empty but the other one filled: give it to the host
    if ((st_n[host_n] != SLOT_FULL) && (st_n[host_n ^ 1'b1] == SLOT_FULL)) begin
      host_n = host_n ^ 1'b1;
    end

    // scan for the transmit stage
    held_b = 1'b0;
    free_b = 1'b0; free_b_idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (st_n[i] == SLOT_HELD) held_b = 1'b1;
      if ((st_n[i] == SLOT_EMPTY) && (!free_b || (IDX_W'(i) != host_n))) begin
        free_b     = 1'b1;
        free_b_idx = IDX_W'(i);
      end
    end

    if (tx_start && !held_b) begin
      if (free_b) begin
        st_n[free_b_idx]  = SLOT_HELD;
        wr_en[free_b_idx] = 1'b1;
        wr_tx[free_b_idx] = 1'b1;
      end else begin
        ovr_evt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SLOTS; i++) st_q[i] <= SLOT_EMPTY;
      host_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) st_q[i] <= st_n[i];
      host_q <= host_n;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_full
    assign slot_full[g] = (st_q[g] == SLOT_FULL);
  end

  assign host_sel = host_q;
  assign rx_full  = (st_q[host_q] == SLOT_FULL);

endmodule

// File: rtl/rxb_overrun_flag.sv
module rxb_overrun_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_evt,
  input  logic clr_cmd,
  output logic flag
);

  logic flag_q, flag_n;

  always_comb begin
    flag_n = flag_q;
    if (set_evt) begin
      flag_n = 1'b1;
    end else if (clr_cmd) begin
      flag_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_n;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/rxb_frame_store.sv
module rxb_frame_store
  import can_rxb_pkg::*;
#(
  parameter int FRAME_W = 64
) (
  input  logic                 clk,
  input  logic [NUM_SLOTS-1:0] wr_en,
  input  logic [NUM_SLOTS-1:0] wr_tx,
  input  logic [FRAME_W-1:0]   rx_frame,
  input  logic [FRAME_W-1:0]   tx_frame,
  input  logic [IDX_W-1:0]     rd_sel,
  output logic [FRAME_W-1:0]   rd_frame
);

  logic [FRAME_W-1:0] slot_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [FRAME_W-1:0] slot_n;

    always_comb begin
      slot_n = slot_q[g];
      if (wr_en[g]) begin
        slot_n = wr_tx[g] ? tx_frame : rx_frame;
      end
    end

    always_ff @(posedge clk) begin
      slot_q[g] <= slot_n;
    end
  end

  assign rd_frame = slot_q[rd_sel];

endmodule

// File: rtl/can_rx_dualbuf.sv
module can_rx_dualbuf
  import can_rxb_pkg::*;
#(
  parameter int FRAME_W    = 64,
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_store,
  input  logic [FRAME_W-1:0] rx_frame,
  input  logic               tx_start,
  input  logic [FRAME_W-1:0] tx_frame,
  input  logic               tx_done,
  input  logic               host_release,
  input  logic               host_clr_ovr,
  output logic               rx_full,
  output logic               overrun,
  output logic [FRAME_W-1:0] host_frame
);

  logic                 rst_sync_n;
  logic [NUM_SLOTS-1:0] wr_en;
  logic [NUM_SLOTS-1:0] wr_tx;
  logic [IDX_W-1:0]     host_sel;
  logic [NUM_SLOTS-1:0] slot_full;
  logic                 ovr_evt;

  rxb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxb_owner_fsm u_fsm (
    .clk          (clk),
    .rst_ni       (rst_sync_n),
    .rx_store     (rx_store),
    .tx_start     (tx_start),
    .tx_done      (tx_done),
    .host_release (host_release),
    .wr_en        (wr_en),
    .wr_tx        (wr_tx),
    .host_sel     (host_sel),
    .slot_full    (slot_full),
    .rx_full      (rx_full),
    .ovr_evt      (ovr_evt)
  );

  rxb_overrun_flag u_ovr (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .set_evt (ovr_evt),
    .clr_cmd (host_clr_ovr),
    .flag    (overrun)
  );

  rxb_frame_store #(.FRAME_W(FRAME_W)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_tx    (wr_tx),
    .rx_frame (rx_frame),
    .tx_frame (tx_frame),
    .rd_sel   (host_sel),
    .rd_frame (host_frame)
  );

endmodule

// File: rtl/can_rx_dualbuf_chk.sv
module can_rx_dualbuf_chk
  import can_rxb_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_store,
  input logic                 tx_start,
  input logic                 host_release,
  input logic                 host_clr_ovr,
  input logic                 rx_full,
  input logic                 overrun,
  input logic [NUM_SLOTS-1:0] slot_full
);

  // R2
  full_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_store));

  // R4
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_release && (&slot_full)) |=> rx_full);

  // R3
  host_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_full) |-> rx_full);

  // R5
  ovr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_store || tx_start));

  // R6
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !host_clr_ovr) |=> overrun);

  // R6
  ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(host_clr_ovr));

endmodule

bind can_rx_dualbuf can_rx_dualbuf_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_store     (rx_store),
  .tx_start     (tx_start),
  .host_release (host_release),
  .host_clr_ovr (host_clr_ovr),
  .rx_full      (rx_full),
  .overrun      (overrun),
  .slot_full    (slot_full)
);

// File: tb/tb_can_rx_dualbuf.sv
module tb_can_rx_dualbuf;

  localparam int  FW         = 16;
  localparam time CLK_PERIOD = 10ns;

  logic          clk;
  logic          rst_n;
  logic          rx_store, tx_start, tx_done, host_release, host_clr_ovr;
  logic [FW-1:0] rx_frame, tx_frame;
  logic          rx_full, overrun;
  logic [FW-1:0] host_frame;

  int checks   = 0;
  int failures = 0;
  string cur_req = "R1";

  // reference model
  logic [FW-1:0] mq[$];
  bit            mhold;
  bit            movr;
  logic [FW-1:0] tag;

  can_rx_dualbuf #(.FRAME_W(FW), .RST_STAGES(2)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_store     (rx_store),
    .rx_frame     (rx_frame),
    .tx_start     (tx_start),
    .tx_frame     (tx_frame),
    .tx_done      (tx_done),
    .host_release (host_release),
    .host_clr_ovr (host_clr_ovr),
    .rx_full      (rx_full),
    .overrun      (overrun),
    .host_frame   (host_frame)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic chk(string req, string what, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_store = 0; tx_start = 0; tx_done = 0; host_release = 0; host_clr_ovr = 0;
  endtask

  task automatic model_update();
    bit set = 0;
    if (host_release && mq.size() > 0) void'(mq.pop_front());
    if (tx_done) mhold = 0;
    if (rx_store) begin
      if (mhold) begin mq.push_back(rx_frame); mhold = 0; end
      else if (mq.size() < 2) mq.push_back(rx_frame);
      else set = 1;
    end
    if (tx_start && !mhold) begin
      if (mq.size() < 2) mhold = 1;
      else set = 1;
    end
    if (set) movr = 1;
    else if (host_clr_ovr) movr = 0;
  endtask

  task automatic compare();
    chk(cur_req, "rx_full", FW'(rx_full), FW'(mq.size() > 0));
    chk(cur_req, "overrun", FW'(overrun), FW'(movr));
    if (mq.size() > 0) chk(cur_req, "host_frame", host_frame, mq[0]);
  endtask

  // one clock: inputs set before the call, model follows the edge, compare after
  task automatic step();
    @(posedge clk);
    model_update();
    #1;
    compare();
    idle_inputs();
  endtask

  task automatic store();
    tag = tag + 1;
    rx_store = 1; rx_frame = tag;
  endtask

  task automatic tx_go();
    tx_start = 1; tx_frame = ~tag;
  endtask

  task automatic drain();
    repeat (3) begin host_release = 1; step(); end
    host_clr_ovr = 1; step();
    tx_done = 1; step();
  endtask

  initial begin
    idle_inputs();
    rx_frame = '0; tx_frame = '0; tag = 16'h0A00;
    mhold = 0; movr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    cur_req = "R1";
    compare();
    step();

    // R2 first frame becomes visible
    cur_req = "R2";
    store(); step();
    chk("R2", "rx_full after store", FW'(rx_full), FW'(1));
    chk("R2", "frame after store", host_frame, tag);

    // R3 release to empty, then release ignored
    cur_req = "R3";
    host_release = 1; step();
    chk("R3", "rx_full after release", FW'(rx_full), FW'(0));
    host_release = 1; step();
    step();

    // R4 handover of the waiting frame
    cur_req = "R4";
    store(); step(); store(); step();
    host_release = 1; step();
    chk("R4", "rx_full after handover", FW'(rx_full), FW'(1));
    chk("R4", "second frame visible", host_frame, tag);

    // R5 overrun drops the frame
    cur_req = "R5";
    store(); step();
    store(); step();
    chk("R5", "overrun set", FW'(overrun), FW'(1));
    chk("R5", "host frame kept", host_frame, tag - 2);

    // R6 set wins over clear, clear alone works
    cur_req = "R6";
    store(); host_clr_ovr = 1; step();
    chk("R6", "overrun set beats clear", FW'(overrun), FW'(1));
    repeat (3) step();
    host_clr_ovr = 1; step();
    chk("R6", "overrun cleared", FW'(overrun), FW'(0));

    // R10 release and store together with both slots full
    cur_req = "R10";
    host_release = 1; store(); step();
    chk("R10", "no overrun", FW'(overrun), FW'(0));
    host_release = 1; step();
    chk("R10", "new frame queued", host_frame, tag);
    drain();

    // R7 reservation with space, then without
    cur_req = "R7";
    store(); step(); tx_go(); step();
    chk("R7", "reserve keeps rx_full", FW'(rx_full), FW'(1));
    // R9 frame lands in the reserved slot behind the older one
    cur_req = "R9";
    store(); step();
    host_release = 1; step();
    chk("R9", "reserved slot frame", host_frame, tag);
    store(); step();
    cur_req = "R7";
    tx_go(); step();
    chk("R7", "no slot for transmit", FW'(overrun), FW'(1));
    drain();

    // R8 successful transmission frees the slot silently
    cur_req = "R8";
    tx_go(); step();
    tx_done = 1; step();
    chk("R8", "rx_full stays low", FW'(rx_full), FW'(0));
    store(); step(); store(); step();
    chk("R8", "freed slot reused", FW'(overrun), FW'(0));
    drain();

    // R11 second transmit start ignored
    cur_req = "R11";
    tx_go(); step(); tx_go(); step();
    store(); step(); store(); step();
    chk("R11", "no extra reservation", FW'(overrun), FW'(0));
    drain();

    // random mix of all commands
    cur_req = "R9";
    void'($urandom(32'd7));
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 2) == 0) store();
      if ($urandom_range(0, 6) == 0) tx_go();
      if ($urandom_range(0, 7) == 0) tx_done = 1;
      if ($urandom_range(0, 3) == 0) host_release = 1;
      if ($urandom_range(0, 9) == 0) host_clr_ovr = 1;
      step();
    end

    finish_run();
  end

endmodule